// File: doc/BRIEF.md
# Banked Interrupt Controller

This block collects up to 64 interrupt lines into two banks of 32 sources each. It presents them to a host processor through a small word-addressed register bus and drives one interrupt request. Each source is either edge-type or level-type. A fixed per-bank mask parameter picks the level-type sources.

An edge-type source records a rising edge in a sticky event bit. The host clears that bit by writing a one to the matching position of the acknowledge register. A level-type source is never latched. It is pending for as long as its line is high and it is enabled. Each bank has an enable register and a level register. The level register shows the live lines. Among all pending sources, the one with the highest number is reported on a registered index output, together with a valid flag.

Enabling an edge-type source whose line is already high has no effect. No event is recorded and no request is raised. Only a later rising edge counts. Register data is little-endian: bit k of a bus word is bit k of the bank, so byte lane 0 carries bits 7:0.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, every enable register and every event register reads zero, and `irq_o` and `irq_idx_vld_o` are low.
- R2: An edge-type source sets its event bit only on a rising edge of its line while its enable bit is set. Setting an enable bit while that line is already high sets no event bit and raises no request.
- R3: Writing the acknowledge register clears each event bit whose written bit is 1. Written 0 bits leave event bits unchanged. A set and a clear on the same bit in the same cycle leave the bit set.
- R4: The enable register of each bank reads back exactly the last value written to it.
- R5: A source whose mask bit is 1 is level-type (default mask 0x1ff00000 in each bank, bits 20 to 28). It never sets an event bit. It is pending while its line is high and it is enabled, and it stops being pending when the line falls.
- R6: The level register of a bank reads the current state of that bank's 32 input lines.
- R7: Bank 0 (sources 0 to 31) starts at word address 8 (byte 0x20). Bank 1 (sources 32 to 63) starts at word address 4 (byte 0x10). Within a bank, the registers sit at word offsets +0 event, +1 enable, +2 acknowledge, +3 level. Word addresses 0 to 3 and 12 to 15 read zero. The acknowledge register reads zero. Writes to the event and level registers are ignored. Read data appears on `bus_rdata_o` one cycle after the read request.
- R8: A source is pending when (event OR (line AND mask)) AND enable. `irq_o` is the OR of all pending bits, registered one cycle. `irq_idx_o` gives the highest pending source number, and `irq_idx_vld_o` qualifies it in the same cycle.
- R9: Source n is bit n&31 of bank n>>5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Interrupt source lines, already synchronous to clk |
| bus_sel_i | input | 1 | Bus access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Word address within the 16-word window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid one cycle after a read |
| irq_o | output | 1 | Interrupt request |
| irq_idx_o | output | 6 | Number of the highest pending source |
| irq_idx_vld_o | output | 1 | Qualifies irq_idx_o |

## Verification
The bench builds the block with its default parameters: two banks of 32 and the 0x1ff00000 mask in both banks. The full 64-source space is therefore covered, with nine level-type sources in each bank. This size lets the bench sweep every source in turn: enable it alone, stimulate it, check the reported index and the register view, then acknowledge it. It then crosses many source pairs in both banks to check the priority order. Dedicated sequences cover enabling a source whose line is already high, a set and a clear on the same bit in the same cycle, enable readback patterns, and the unmapped words.

// File: rtl/birq_pkg.sv
package birq_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        RSEL_EVENT  = 2'd0,
        RSEL_ENABLE = 2'd1,
        RSEL_ACK    = 2'd2,
        RSEL_LEVEL  = 2'd3
    } reg_sel_e;

    // Address group (bus_addr[3:2]) occupied by bank b: bank 0 -> 2, bank 1 -> 1
    function automatic logic [1:0] bank_group(input int b);
        return 2'(2 - b);
    endfunction

endpackage

// File: rtl/birq_bank.sv
module birq_bank #(
    parameter int              W        = 32,
    parameter logic [W-1:0]    LVL_MASK = 32'h1ff0_0000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line_i,
    input  logic         ena_we_i,
    input  logic         ack_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] event_o,
    output logic [W-1:0] enable_o,
    output logic [W-1:0] level_o,
    output logic [W-1:0] pend_o
);

    typedef struct packed {
        logic [W-1:0] line;
        logic [W-1:0] evt;
        logic [W-1:0] ena;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [W-1:0] set_v;
    logic [W-1:0] clr_v;

    always_comb begin
        st_d      = st_q;
        set_v     = line_i & ~st_q.line & st_q.ena & ~LVL_MASK;
        clr_v     = ack_we_i ? wdata_i : '0;
        st_d.line = line_i;
        st_d.evt  = (st_q.evt & ~clr_v) | set_v;
        if (ena_we_i) begin
            st_d.ena = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign event_o  = st_q.evt;
    assign enable_o = st_q.ena;
    assign level_o  = line_i;
    assign pend_o   = (st_q.evt | (line_i & LVL_MASK)) & st_q.ena;

    // R2: a new event bit needs an enabled rising edge in the previous cycle
    a_r2_event_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.evt & ~$past(st_q.evt)
                   & ~$past(line_i & ~st_q.line & st_q.ena)) == '0));

    // R3: acknowledged bits without a concurrent set are clear afterwards
    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ack_we_i |=> ((st_q.evt & $past(wdata_i & ~set_v)) == '0));

    // R4: the enable register only changes through a write
    a_r4_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ena_we_i |=> $stable(st_q.ena));

    // R5: level-type positions never hold an event
    a_r5_level_unlatched: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.evt & LVL_MASK) == '0));

endmodule

// File: rtl/birq_prio.sv
module birq_prio #(
    parameter int N  = 64,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    output logic [IW-1:0] idx_o,
    output logic          vld_o
);

    always_comb begin
        idx_o = '0;
        vld_o = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i]) begin
                idx_o = IW'(i);
                vld_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl #(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 32,
    parameter logic [NUM_BANKS*BANK_W-1:0] LVL_MASK = {2{32'h1ff0_0000}},
    localparam int NUM_SRC  = NUM_BANKS * BANK_W,
    localparam int IDX_W    = $clog2(NUM_SRC),
    localparam int AW       = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_sel_i,
    input  logic               bus_we_i,
    input  logic [AW-1:0]      bus_addr_i,
    input  logic [BANK_W-1:0]  bus_wdata_i,
    output logic [BANK_W-1:0]  bus_rdata_o,
    output logic               irq_o,
    output logic [IDX_W-1:0]   irq_idx_o,
    output logic               irq_idx_vld_o
);
    import birq_pkg::*;

    typedef struct packed {
        logic [BANK_W-1:0] rdata;
        logic              irq;
        logic [IDX_W-1:0]  idx;
        logic              vld;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [1:0]         grp;
    reg_sel_e           rsel;
    logic [NUM_SRC-1:0] pend_all;
    logic [BANK_W-1:0]  b_event [NUM_BANKS];
    logic [BANK_W-1:0]  b_enable[NUM_BANKS];
    logic [BANK_W-1:0]  b_level [NUM_BANKS];
    logic [IDX_W-1:0]   enc_idx;
    logic               enc_vld;

    assign grp  = bus_addr_i[3:2];
    assign rsel = reg_sel_e'(bus_addr_i[1:0]);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = bus_sel_i && bus_we_i && (grp == bank_group(b));

        birq_bank #(
            .W        (BANK_W),
            .LVL_MASK (LVL_MASK[b*BANK_W +: BANK_W])
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_i   (src_i[b*BANK_W +: BANK_W]),
            .ena_we_i (hit && (rsel == RSEL_ENABLE)),
            .ack_we_i (hit && (rsel == RSEL_ACK)),
            .wdata_i  (bus_wdata_i),
            .event_o  (b_event[b]),
            .enable_o (b_enable[b]),
            .level_o  (b_level[b]),
            .pend_o   (pend_all[b*BANK_W +: BANK_W])
        );
    end

    birq_prio #(
        .N  (NUM_SRC),
        .IW (IDX_W)
    ) u_prio (
        .req_i (pend_all),
        .idx_o (enc_idx),
        .vld_o (enc_vld)
    );

    always_comb begin
        st_d       = st_q;
        st_d.irq   = |pend_all;
        st_d.idx   = enc_idx;
        st_d.vld   = enc_vld;
        if (bus_sel_i && !bus_we_i) begin
            st_d.rdata = '0;
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (grp == bank_group(b)) begin
                    case (rsel)
                        RSEL_EVENT:  st_d.rdata = b_event[b];
                        RSEL_ENABLE: st_d.rdata = b_enable[b];
                        RSEL_LEVEL:  st_d.rdata = b_level[b];
                        default:     st_d.rdata = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata_o   = st_q.rdata;
    assign irq_o         = st_q.irq;
    assign irq_idx_o     = st_q.idx;
    assign irq_idx_vld_o = st_q.vld;

    // R8: request and index qualifier agree
    a_r8_irq_vld_agree: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == irq_idx_vld_o);

    // R8: the reported source was pending in the cycle it was captured
    a_r8_idx_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_idx_vld_o |-> ((($past(pend_all) >> irq_idx_o) & NUM_SRC'(1)) != '0));

    // R8: no source above the reported one was pending
    a_r8_idx_highest: assert property (@(posedge clk) disable iff (!rst_n)
        irq_idx_vld_o |-> ((($past(pend_all) >> irq_idx_o) >> 1) == '0));

    // R7: words outside both banks read zero
    a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && !bus_we_i && (grp == 2'd0 || grp == 2'd3)) |=> (bus_rdata_o == '0));

endmodule

// File: tb/banked_irq_ctrl_bench.sv
`timescale 1ns/1ps
module banked_irq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        sel = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [5:0]  idx;
    logic        vld;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    banked_irq_ctrl u_banked_irq_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .src_i         (src),
        .bus_sel_i     (sel),
        .bus_we_i      (we),
        .bus_addr_i    (addr),
        .bus_wdata_i   (wdata),
        .bus_rdata_o   (rdata),
        .irq_o         (irq),
        .irq_idx_o     (idx),
        .irq_idx_vld_o (vld)
    );

    localparam logic [31:0] MASK = 32'h1ff0_0000;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        d = rdata;
        sel = 1'b0;
    endtask

    function automatic logic [3:0] base_of(input int n);
        return (n < 32) ? 4'd8 : 4'd4;
    endfunction

    function automatic bit is_lvl(input int n);
        return MASK[n % 32];
    endfunction

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state
        chk("R1 irq", {63'd0, irq}, 64'd0);
        chk("R1 vld", {63'd0, vld}, 64'd0);
        for (int a = 0; a < 16; a++) begin
            if (a % 4 == 0 || a % 4 == 1) begin
                rd(4'(a), d);
                chk("R1 reg zero", {32'd0, d}, 64'd0);
            end
        end

        // R4 enable readback, R7 unmapped and ignored writes
        foreach (d[i]) ;
        for (int b = 0; b < 2; b++) begin
            logic [3:0] base;
            base = (b == 0) ? 4'd8 : 4'd4;
            wr(base + 4'd1, 32'hA5C3_0F69 ^ 32'(b));
            rd(base + 4'd1, d);
            chk("R4 enable readback", {32'd0, d}, {32'd0, 32'hA5C3_0F69 ^ 32'(b)});
            wr(base + 4'd1, 32'h0);
            wr(base + 4'd0, 32'hFFFF_FFFF);
            rd(base + 4'd0, d);
            chk("R7 event write ignored", {32'd0, d}, 64'd0);
            rd(base + 4'd2, d);
            chk("R7 ack reads zero", {32'd0, d}, 64'd0);
        end
        rd(4'd0, d);  chk("R7 unmapped 0", {32'd0, d}, 64'd0);
        rd(4'd13, d); chk("R7 unmapped 13", {32'd0, d}, 64'd0);

        // R9/R2/R3/R5/R6/R8 per-source sweep
        for (int n = 0; n < 64; n++) begin
            logic [3:0]  base;
            logic [31:0] bitv;
            base = base_of(n);
            bitv = 32'd1 << (n % 32);
            wr(base + 4'd1, bitv);
            @(negedge clk); src[n] = 1'b1;
            tick(3);
            chk("R8 irq sweep", {63'd0, irq}, 64'd1);
            chk("R9 idx sweep", {58'd0, idx}, 64'(n));
            rd(base + 4'd3, d);
            chk("R6 level", {32'd0, d}, {32'd0, bitv});
            rd(base + 4'd0, d);
            if (is_lvl(n)) begin
                chk("R5 no latch", {32'd0, d}, 64'd0);
                @(negedge clk); src[n] = 1'b0;
                tick(3);
                chk("R5 drop", {63'd0, irq}, 64'd0);
            end else begin
                chk("R2 event set", {32'd0, d}, {32'd0, bitv});
                wr(base + 4'd2, ~bitv);
                rd(base + 4'd0, d);
                chk("R3 zeros no effect", {32'd0, d}, {32'd0, bitv});
                wr(base + 4'd2, bitv);
                tick(2);
                rd(base + 4'd0, d);
                chk("R3 ack clear", {32'd0, d}, 64'd0);
                chk("R3 irq low", {63'd0, irq}, 64'd0);
                @(negedge clk); src[n] = 1'b0;
            end
            wr(base + 4'd1, 32'd0);
        end

        // R2 enabling while the line is already high
        @(negedge clk); src[5] = 1'b1; src[40] = 1'b1;
        tick(3);
        wr(4'd9, 32'd1 << 5);
        wr(4'd5, 32'd1 << 8);
        tick(3);
        chk("R2 late enable irq", {63'd0, irq}, 64'd0);
        rd(4'd8, d); chk("R2 late enable bank0", {32'd0, d}, 64'd0);
        rd(4'd4, d); chk("R2 late enable bank1", {32'd0, d}, 64'd0);
        @(negedge clk); src[5] = 1'b0; src[40] = 1'b0;
        tick(2);
        @(negedge clk); src[40] = 1'b1;
        tick(3);
        chk("R2 next edge counts", {58'd0, idx}, 64'd40);
        wr(4'd6, 32'd1 << 8);
        @(negedge clk); src[40] = 1'b0;
        wr(4'd9, 32'd0); wr(4'd5, 32'd0);

        // R3 set beats clear in the same cycle
        wr(4'd9, 32'd1 << 3);
        @(negedge clk);
        src[3] = 1'b1; sel = 1'b1; we = 1'b1; addr = 4'd10; wdata = 32'd1 << 3;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
        rd(4'd8, d);
        chk("R3 set wins", {32'd0, d}, 64'd1 << 3);
        wr(4'd10, 32'hFFFF_FFFF);
        @(negedge clk); src[3] = 1'b0;
        wr(4'd9, 32'd0);

        // R8 priority across pairs
        wr(4'd9, 32'hFFFF_FFFF);
        wr(4'd5, 32'hFFFF_FFFF);
        for (int a = 0; a < 64; a += 7) begin
            for (int b = 1; b < 64; b += 5) begin
                @(negedge clk); src[a] = 1'b1; src[b] = 1'b1;
                tick(3);
                chk("R8 pair irq", {63'd0, irq}, 64'd1);
                chk("R8 pair idx", {58'd0, idx}, 64'((a > b) ? a : b));
                @(negedge clk); src = '0;
                wr(4'd10, 32'hFFFF_FFFF);
                wr(4'd6, 32'hFFFF_FFFF);
                tick(2);
                chk("R8 pair cleared", {63'd0, vld}, 64'd0);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule